// File: doc/BRIEF.md
# Byte ALU with Condition Flags and Two-Cycle Word Immediate

The block computes 8-bit arithmetic, logic and shift results from two byte operands or from one byte and an immediate. The caller presents an immediate on the second operand port, so immediate forms use the same codes as register forms. The block keeps a six-bit condition register that each operation updates under its own rules. It also adds a 6-bit unsigned constant to a 16-bit register pair, or subtracts it from the pair. A word operation takes two clock cycles and holds a busy indication during the first.

A caller raises `start` for one cycle with an operation code and its operands. A byte operation is accepted at that clock edge. Its result, flags and a one-cycle `done` pulse appear right after that edge. A word operation computes its low byte at the accept edge and its high byte and flags at the next edge, and `done` pulses then. The flag register lives inside the block. The carry that chained operations consume enters on `cin`, so the caller chooses where that carry comes from.

Top module: `alu8_flags`

## Requirements
- R1: After reset, `result` is 0, `flags` is 0, `pair_reg` is 0, and `busy` and `done` are low. Flag bit positions are: bit 0 C, bit 1 Z, bit 2 N, bit 3 V, bit 4 S, bit 5 H.
- R2: A byte operation (any code other than 17 and 18) accepted while idle raises `done` for exactly the next cycle, and `busy` stays low. Codes 19 to 31 complete the same way and change neither `result` nor `flags`.
- R3: A word operation (code 17 add, code 18 subtract) raises `busy` for one cycle after acceptance. `done` follows in the cycle after that, with `busy` low. A `start` seen while `busy` is high is ignored.
- R4: Code 0 (add) and code 1 (add with `cin`) write `result[7:0]`, with `result[15:8]` = 0. C is the carry out of bit 7, H is the carry out of bit 3, V is two's-complement overflow, N is bit 7 of the result and Z is set when the result byte is zero.
- R5: Code 2 (subtract), code 3 (subtract with `cin` as borrow-in) and code 10 (negate, 0 minus `opa`) write the difference. C is the borrow out of bit 7, H is the borrow out of bit 3 and V is signed overflow.
- R6: For codes 3 and 5, Z is cleared on a nonzero result byte and otherwise keeps its previous value.
- R7: Compare codes 4 (plain) and 5 (with `cin`) set the flags as a subtraction would and leave `result` unchanged.
- R8: Codes 6 (AND), 7 (OR), 8 (XOR) and 9 (one's complement of `opa`) clear V and keep C and H. Code 9 sets C.
- R9: Code 11 (increment) and code 12 (decrement) keep C and H. V is set only for results 0x80 and 0x7F respectively.
- R10: The shift codes move `opa` right by one bit and put the old bit 0 into C, with V = N xor C. Bit 7 is filled with 0 for code 13, with `cin` for code 14, and with the old bit 7 for code 15.
- R11: S equals N xor V at all times.
- R12: A word operation returns `pair_val` plus or minus `imm6` on all 16 bits of `result`. C is the carry or borrow out of bit 15, V is signed overflow, Z is set on a zero word, N is bit 15, and H keeps its value. `pair_reg` reports 24 + 2 x `pair_sel`.
- R13: Code 16 swaps the nibbles of `opa` into `result` and leaves every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept an operation this cycle when idle |
| op | input | 5 | Operation code |
| opa | input | 8 | First byte operand |
| opb | input | 8 | Second byte operand or byte immediate |
| cin | input | 1 | Incoming carry or borrow for the chained codes and the rotate |
| pair_val | input | 16 | Register pair value for word operations |
| pair_sel | input | 2 | Register pair selector for word operations |
| imm6 | input | 6 | Unsigned constant for word operations |
| result | output | 16 | Last written result (byte results zero-extended) |
| flags | output | 6 | Condition register {H,S,V,N,Z,C} |
| pair_reg | output | 5 | Low register index of the last word operation's pair |
| busy | output | 1 | Word operation in its first cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a `start` that arrives in the busy cycle of a word operation. That request must be dropped while the high byte finishes from the latched pair. The random phase therefore sometimes holds `start` high for two cycles with a new operation code, which reaches this case. The Z chain over several subtract-with-carry bytes needs a known Z before each step, so directed sequences first force Z set or clear with a compare and then run chains whose bytes are zero or nonzero. Flag boundaries such as signed overflow at 0x7F/0x80, borrow out of bit 3 and word wrap at 0xFFFF/0x0000 are reached with chosen operand pairs.

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [4:0]  op,
  input  logic [7:0]  opa,
  input  logic [7:0]  opb,
  input  logic        cin,
  input  logic [15:0] pair_val,
  input  logic [1:0]  pair_sel,
  input  logic [5:0]  imm6,
  output logic [15:0] result,
  output logic [5:0]  flags,
  output logic [4:0]  pair_reg,
  output logic        busy,
  output logic        done
);
  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3;
  localparam logic [4:0] OP_CP  = 5'd4,  OP_CPC = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7;
  localparam logic [4:0] OP_XOR = 5'd8,  OP_COM = 5'd9,  OP_NEG = 5'd10, OP_INC = 5'd11;
  localparam logic [4:0] OP_DEC = 5'd12, OP_LSR = 5'd13, OP_ROR = 5'd14, OP_ASR = 5'd15;
  localparam logic [4:0] OP_SWP = 5'd16, OP_WAD = 5'd17, OP_WSB = 5'd18;
  localparam int FC = 0, FZ = 1, FN = 2, FV = 3, FS = 4, FH = 5;

  // shared byte adder
  logic [7:0] ax, ay, yy, ar;
  logic       inv, acin, ac, ah, av, as, az, zc;
  logic [8:0] sum9, sx9;
  logic [4:0] nib5;

  always_comb begin
    ax = opa; ay = opb; inv = 1'b0; acin = 1'b0;
    case (op)
      OP_ADC:                acin = cin;
      OP_SUB, OP_CP:         begin inv = 1'b1; acin = 1'b1; end
      OP_SBC, OP_CPC:        begin inv = 1'b1; acin = ~cin; end
      OP_NEG:                begin ax = 8'h00; ay = opa; inv = 1'b1; acin = 1'b1; end
      OP_INC:                begin ay = 8'h00; acin = 1'b1; end
      OP_DEC:                ay = 8'hFF;
      default: ;
    endcase
  end

  assign yy   = inv ? ~ay : ay;
  assign sum9 = {1'b0, ax} + {1'b0, yy} + {8'd0, acin};
  assign nib5 = {1'b0, ax[3:0]} + {1'b0, yy[3:0]} + {4'd0, acin};
  assign sx9  = {ax[7], ax} + {yy[7], yy} + {8'd0, acin};
  assign ar   = sum9[7:0];
  assign ac   = inv ? ~sum9[8] : sum9[8];
  assign ah   = inv ? ~nib5[4] : nib5[4];
  assign av   = (ax[7] == yy[7]) && (ar[7] != ax[7]);
  assign as   = sx9[8];
  assign az   = (ar == 8'h00);
  assign zc   = (op == OP_SBC || op == OP_CPC) ? (az & flags[FZ]) : az;

  // logic and shift units
  logic [7:0] lres, sres;
  logic       sfill;

  always_comb begin
    case (op)
      OP_AND:  lres = opa & opb;
      OP_OR:   lres = opa | opb;
      OP_XOR:  lres = opa ^ opb;
      default: lres = ~opa;
    endcase
    case (op)
      OP_ROR:  sfill = cin;
      OP_ASR:  sfill = opa[7];
      default: sfill = 1'b0;
    endcase
  end

  assign sres = {sfill, opa[7:1]};

  // byte outcome
  logic [7:0] bres;
  logic [5:0] bfl;
  logic       bwr;

  always_comb begin
    bres = result[7:0];
    bfl  = flags;
    bwr  = 1'b0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
        bres = ar; bwr = 1'b1;
        bfl  = {ah, as, av, ar[7], zc, ac};
      end
      OP_CP, OP_CPC:
        bfl = {ah, as, av, ar[7], zc, ac};
      OP_AND, OP_OR, OP_XOR, OP_COM: begin
        bres = lres; bwr = 1'b1;
        bfl  = {flags[FH], lres[7], 1'b0, lres[7], lres == 8'h00,
                (op == OP_COM) ? 1'b1 : flags[FC]};
      end
      OP_INC, OP_DEC: begin
        bres = ar; bwr = 1'b1;
        bfl  = {flags[FH], as, av, ar[7], az, flags[FC]};
      end
      OP_LSR, OP_ROR, OP_ASR: begin
        bres = sres; bwr = 1'b1;
        bfl  = {flags[FH], opa[0], sres[7] ^ opa[0], sres[7], sres == 8'h00, opa[0]};
      end
      OP_SWP: begin
        bres = {opa[3:0], opa[7:4]}; bwr = 1'b1;
      end
      default: ;
    endcase
  end

  // word path: low byte at accept, high byte one cycle later
  logic       wsub_n;
  logic [8:0] lo9;
  logic [7:0] w_lo, w_hi, wyy;
  logic       w_c, w_sub;
  logic [8:0] hi9, hs9;
  logic [15:0] wres;
  logic       wc, wv;

  assign wsub_n = (op == OP_WSB);
  assign lo9 = {1'b0, pair_val[7:0]}
             + {1'b0, wsub_n ? ~{2'b00, imm6} : {2'b00, imm6}}
             + {8'd0, wsub_n};

  assign wyy  = {8{w_sub}};
  assign hi9  = {1'b0, w_hi} + {1'b0, wyy} + {8'd0, w_c};
  assign hs9  = {w_hi[7], w_hi} + {w_sub, wyy} + {8'd0, w_c};
  assign wres = {hi9[7:0], w_lo};
  assign wc   = w_sub ? ~hi9[8] : hi9[8];
  assign wv   = (w_hi[7] == w_sub) && (hi9[7] != w_hi[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result   <= '0;
      flags    <= '0;
      pair_reg <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      w_lo     <= '0;
      w_hi     <= '0;
      w_c      <= 1'b0;
      w_sub    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        result <= wres;
        flags  <= {flags[FH], hs9[8], wv, wres[15], wres == 16'h0000, wc};
      end else if (start) begin
        if (op == OP_WAD || op == OP_WSB) begin
          busy     <= 1'b1;
          w_lo     <= lo9[7:0];
          w_c      <= lo9[8];
          w_hi     <= pair_val[15:8];
          w_sub    <= wsub_n;
          pair_reg <= 5'd24 + {2'b00, pair_sel, 1'b0};
        end else begin
          done  <= 1'b1;
          flags <= bfl;
          if (bwr) result <= {8'h00, bres};
        end
      end
    end
  end
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [4:0]  op,
  input logic [15:0] result,
  input logic [5:0]  flags,
  input logic        busy,
  input logic        done
);
  logic acc;
  assign acc = start && !busy;

  p_sign_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flags[4] == (flags[2] ^ flags[3]));

  p_byte_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op != 5'd17 && op != 5'd18) |=> (done && !busy));

  p_word_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (op == 5'd17 || op == 5'd18)) |=> (busy && !done));

  p_word_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy && done));

  p_cmp_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (op == 5'd4 || op == 5'd5)) |=> $stable(result));

  p_zchain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (op == 5'd3 || op == 5'd5) && !flags[1]) |=> !flags[1]);

  p_swap_flags_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == 5'd16) |=> $stable(flags));
endmodule

bind alu8_flags alu8_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op),
  .result(result), .flags(flags), .busy(busy), .done(done)
);

// File: tb/tb_alu8_flags.sv
module tb_alu8_flags;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  op = '0;
  logic [7:0]  opa = '0, opb = '0;
  logic        cin = 1'b0;
  logic [15:0] pair_val = '0;
  logic [1:0]  pair_sel = '0;
  logic [5:0]  imm6 = '0;
  logic [15:0] result;
  logic [5:0]  flags;
  logic [4:0]  pair_reg;
  logic        busy, done;

  alu8_flags dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
    .cin(cin), .pair_val(pair_val), .pair_sel(pair_sel), .imm6(imm6),
    .result(result), .flags(flags), .pair_reg(pair_reg), .busy(busy), .done(done)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit reported = 0;
  string cur_req = "R1";

  // reference model state
  int m_res = 0, m_flags = 0, m_pair = 0, p_res = 0, p_fl = 0;
  bit m_busy = 0, m_done = 0;

  function automatic int sx8(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic int pk(int c, int z, int n, int v, int h);
    return (h << 5) | (((n ^ v) & 1) << 4) | (v << 3) | (n << 2) | (z << 1) | c;
  endfunction

  function automatic int bit_of(int v, int b);
    return (v >> b) & 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_res = 0; m_flags = 0; m_pair = 0; m_busy = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_busy = 0; m_done = 1;
        m_res = p_res;
        m_flags = (p_fl & 'h1F) | (m_flags & 'h20);
      end else if (start) begin
        int o, a, b, c, r, t, oc, oz, oh;
        o = op; a = opa; b = opb; c = cin;
        oc = bit_of(m_flags, 0); oz = bit_of(m_flags, 1); oh = bit_of(m_flags, 5);
        if (o == 17 || o == 18) begin
          int w, s, ws;
          w = pair_val;
          ws = (w >= 32768) ? w - 65536 : w;
          s = (o == 17) ? w + imm6 : w - imm6;
          t = (o == 17) ? ws + imm6 : ws - imm6;
          r = s & 'hFFFF;
          p_res = r;
          p_fl = pk((o == 17) ? (s > 65535) : (s < 0), r == 0, bit_of(r, 15),
                    (t > 32767) || (t < -32768), 0);
          m_busy = 1;
          m_pair = 24 + 2 * pair_sel;
        end else begin
          m_done = 1;
          case (o)
            0, 1: begin
              if (o == 0) c = 0;
              r = (a + b + c) & 255;
              t = sx8(a) + sx8(b) + c;
              m_res = r;
              m_flags = pk(a + b + c > 255, r == 0, bit_of(r, 7), (t > 127) || (t < -128),
                           (a & 15) + (b & 15) + c > 15);
            end
            2, 3, 4, 5, 10: begin
              bit chain;
              if (o == 10) begin b = a; a = 0; end
              if (o == 2 || o == 4 || o == 10) c = 0;
              chain = (o == 3 || o == 5);
              r = (a - b - c) & 255;
              t = sx8(a) - sx8(b) - c;
              if (o != 4 && o != 5) m_res = r;
              m_flags = pk(a - b - c < 0, chain ? ((r == 0) && oz) : (r == 0), bit_of(r, 7),
                           (t > 127) || (t < -128), (a & 15) - (b & 15) - c < 0);
            end
            6, 7, 8, 9: begin
              r = (o == 6) ? (a & b) : (o == 7) ? (a | b) : (o == 8) ? (a ^ b) : (~a & 255);
              m_res = r;
              m_flags = pk((o == 9) ? 1 : oc, r == 0, bit_of(r, 7), 0, oh);
            end
            11, 12: begin
              r = (o == 11) ? (a + 1) & 255 : (a + 255) & 255;
              m_res = r;
              m_flags = pk(oc, r == 0, bit_of(r, 7), (o == 11) ? (a == 127) : (a == 128), oh);
            end
            13, 14, 15: begin
              int fill, n, cc;
              fill = (o == 13) ? 0 : (o == 14) ? c : bit_of(a, 7);
              r = (fill << 7) | (a >> 1);
              n = bit_of(r, 7); cc = a & 1;
              m_res = r;
              m_flags = pk(cc, r == 0, n, n ^ cc, oh);
            end
            16: m_res = ((a & 15) << 4) | (a >> 4);
            default: ;
          endcase
        end
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("result", result, m_res);
      chk("flags", flags, m_flags);
      chk("pair_reg", pair_reg, m_pair);
      chk("busy", busy, m_busy);
      chk("done", done, m_done);
    end
  end

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
  endtask

  task automatic byte_op(int o, int a, int b, int c);
    @(negedge clk);
    op = 5'(o); opa = 8'(a); opb = 8'(b); cin = c[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic word_op(int o, int w, int sel, int k, bit hold);
    @(negedge clk);
    op = 5'(o); pair_val = 16'(w); pair_sel = 2'(sel); imm6 = 6'(k); start = 1'b1;
    @(negedge clk);
    if (hold) begin
      op = 5'd0; opa = 8'h11; opb = 8'h22;
      pair_val = 16'h5A5A; pair_sel = 2'(sel + 1);
    end else start = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("reset result", result, 0);
    chk("reset flags", flags, 0);
    chk("reset busy", busy, 0);
    chk("reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("idle pair_reg", pair_reg, 0);

    cur_req = "R4";
    byte_op(0, 8'h7F, 8'h01, 0);
    byte_op(0, 8'hFF, 8'h01, 0);
    byte_op(1, 8'h0F, 8'h00, 1);
    byte_op(1, 8'h80, 8'h80, 1);
    cur_req = "R5";
    byte_op(2, 8'h10, 8'h01, 0);
    byte_op(2, 8'h80, 8'h01, 0);
    byte_op(3, 8'h00, 8'h00, 1);
    byte_op(10, 8'h80, 0, 0);
    byte_op(10, 8'h00, 0, 0);
    byte_op(10, 8'h08, 0, 0);
    cur_req = "R6";
    byte_op(4, 8'h33, 8'h33, 0);
    byte_op(5, 8'h12, 8'h12, 0);
    byte_op(3, 8'h00, 8'h00, 0);
    byte_op(3, 8'h05, 8'h04, 0);
    byte_op(5, 8'h00, 8'h00, 0);
    cur_req = "R7";
    byte_op(0, 8'h21, 8'h21, 0);
    byte_op(4, 8'h10, 8'h20, 0);
    byte_op(5, 8'h10, 8'h10, 1);
    cur_req = "R8";
    byte_op(0, 8'h08, 8'h08, 0);
    byte_op(6, 8'hF0, 8'h0F, 0);
    byte_op(7, 8'h80, 8'h01, 0);
    byte_op(8, 8'hAA, 8'hAA, 0);
    byte_op(9, 8'h00, 0, 0);
    cur_req = "R9";
    byte_op(11, 8'h7F, 0, 0);
    byte_op(11, 8'hFF, 0, 0);
    byte_op(12, 8'h80, 0, 0);
    byte_op(12, 8'h01, 0, 0);
    cur_req = "R10";
    byte_op(13, 8'h81, 0, 1);
    byte_op(14, 8'h02, 0, 1);
    byte_op(15, 8'h81, 0, 0);
    byte_op(15, 8'h01, 0, 0);
    cur_req = "R13";
    byte_op(2, 8'h00, 8'h01, 0);
    byte_op(16, 8'h3C, 0, 0);
    cur_req = "R2";
    byte_op(19, 8'h55, 8'h66, 1);
    byte_op(31, 8'h00, 8'h00, 0);
    cur_req = "R12";
    word_op(17, 16'hFFFF, 0, 1, 0);
    word_op(17, 16'h7FC0, 3, 63, 0);
    word_op(18, 16'h0000, 1, 1, 0);
    word_op(18, 16'h8000, 2, 1, 0);
    word_op(18, 16'h0020, 2, 32, 0);
    cur_req = "R3";
    word_op(17, 16'h00FF, 1, 1, 1);
    word_op(18, 16'h0100, 0, 1, 1);
    cur_req = "R11";
    for (int i = 0; i < 3000; i++) begin
      int o;
      o = $urandom_range(0, 20);
      if (o >= 17 && o <= 18)
        word_op(o, $urandom, $urandom_range(0, 3), $urandom_range(0, 63), $urandom_range(0, 3) == 0);
      else
        byte_op((o > 18) ? $urandom_range(0, 31) : o, $urandom_range(0, 255),
                $urandom_range(0, 255), $urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    report();
    $finish;
  end
endmodule